// File: doc/BRIEF.md
# Static RAM Write Sequencer

The sequencer accepts one write at a time on a valid/ready request port and plays it out as a correctly timed write cycle on an asynchronous static RAM. It drives active-low chip select, write enable and output enable, the address bus, and the data bus as a separate value plus drive-enable pair. Every analog minimum is a nanosecond figure picked by a speed-grade parameter. Each figure is rounded up to whole clock cycles using the clock-period parameter. Each phase of the cycle lasts as long as the strictest rule that applies to it.

The write window is the overlap of chip select low and write enable low. Chip select and the address go active together one cycle before write enable falls. The data drive covers the final setup interval of the pulse and the cycle in which write enable rises. Write enable rises before chip select, and a recovery tail pads the cycle to the minimum cycle time. A build parameter selects one of two output-enable policies. In the first, output enable stays low and the write pulse is lengthened by the output turn-off time, so the RAM releases the bus before the data drive starts. In the second, output enable is raised before write enable falls, and the plain pulse minimum applies.

Back-pressure: a write is taken at a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid` and the payload are ignored, so a producer must hold them until it sees ready. The port carries no other flow control.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted and until the first accepted write, chip select and write enable are high, output enable is low, the data drive is off, `wr_ready` is 1, `busy` is 0 and `done` is 0.
- R2: A write is accepted only at an edge where `wr_valid` and `wr_ready` are both 1. From the next cycle until its `done` cycle, `wr_ready` is 0 and `busy` is 1. A `wr_valid` seen while not ready changes neither the address nor the data that is driven.
- R3: In the first cycle after acceptance, chip select goes low and the accepted address appears, with write enable still high. The address holds that value for as long as chip select stays low.
- R4: Write enable is low only while chip select is low. Chip select rises exactly one cycle after write enable rises.
- R5: Write enable stays low for exactly LOW cycles. LOW is the largest of: ceil(pulse), ceil(cs-to-end) − 1, and ceil(data-setup) + 1. When output enable is held low during writes, LOW is also at least ceil(data-setup) + ceil(turn-off).
- R6: The data drive is on during the last ceil(data-setup) cycles of the write-enable-low window and during the cycle in which write enable rises, and off at every other time. While the drive is on, the driven value is the accepted data.
- R7: With OE_HELD_LOW=1, output enable stays low at all times. With OE_HELD_LOW=0, output enable is high from the cycle chip select falls through the cycle before chip select rises, so it is high before write enable falls.
- R8: After chip select rises, it stays high for max(1, ceil(cycle) − LOW − 2) cycles before `done`.
- R9: `done` is a one-cycle pulse in the first idle cycle after the recovery tail. `wr_ready` is 1 in that cycle, so a back-to-back write can be accepted there.
- R10: GRADE 0, 1 and 2 select, in ns, cycle 55/70/85, pulse 35/50/55, cs-to-end 40/60/75, data-setup 25/30/35 and turn-off 20/25/30. Values are rounded up by CLK_NS. For example, at 10 ns, GRADE 0 with output enable held low gives LOW=5, and GRADE 2 with output enable raised gives LOW=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Sequencer can take a request |
| wr_addr | input | ADDR_W | Request address |
| wr_data | input | DATA_W | Request data |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse when a write cycle finishes |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_dout | output | DATA_W | Data value for the bidirectional bus |
| mem_dout_en | output | 1 | Drive-enable for the data bus |

## Verification
The hardest case to reach is a request that arrives while the sequencer is busy, with a payload that differs from the write in flight. The bench must show that such a request neither restarts the cycle nor leaks onto the address or data pins. The stimulus toggles `wr_valid` with fresh random payloads on most cycles, so requests land in every phase of a cycle. A stretch with `wr_valid` held high makes each `done` cycle also an acceptance, which exercises the back-to-back path. Two instances run side by side, one per output-enable policy and at the fastest and slowest grades. This covers both pulse-length rules and the recovery padding, and each instance is compared every clock against a behavioural queue model.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WLOW  = 3'd2,
    ST_DATA  = 3'd3,
    ST_END   = 3'd4,
    ST_RECOV = 3'd5
  } wr_phase_e;

  // minimum cycle time from one chip-select fall to the next
  function automatic int ns_cycle(input int grade);
    case (grade)
      0:       return 55;
      1:       return 70;
      default: return 85;
    endcase
  endfunction

  // minimum write-enable pulse
  function automatic int ns_pulse(input int grade);
    case (grade)
      0:       return 35;
      1:       return 50;
      default: return 55;
    endcase
  endfunction

  // chip select (and address) to end of write
  function automatic int ns_cs_end(input int grade);
    case (grade)
      0:       return 40;
      1:       return 60;
      default: return 75;
    endcase
  endfunction

  // data setup before end of write
  function automatic int ns_setup(input int grade);
    case (grade)
      0:       return 25;
      1:       return 30;
      default: return 35;
    endcase
  endfunction

  // RAM output turn-off after write enable falls (maximum)
  function automatic int ns_turnoff(input int grade);
    case (grade)
      0:       return 20;
      1:       return 25;
      default: return 30;
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
`timescale 1ns/1ps
module sram_wr_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R5: a running count steps down by one each cycle until it reaches zero
  p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_wr_ctrl.sv
`timescale 1ns/1ps
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int PRE_LEN = 2,
  parameter int DAT_LEN = 3,
  parameter int REC_LEN = 1,
  parameter int CNT_W   = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  output logic      req_ready,
  output logic      accept,
  output wr_phase_e nxt_phase,
  output logic      done
);

  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] DAT_LD = CNT_W'(DAT_LEN - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_LEN - 1);

  wr_phase_e        phase_q;
  wr_phase_e        phase_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             done_q;

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      ST_IDLE: begin
        if (req_valid) phase_d = ST_ADDR;
      end
      ST_ADDR: begin
        phase_d  = ST_WLOW;
        tmr_load = 1'b1;
        tmr_val  = PRE_LD;
      end
      ST_WLOW: begin
        if (tmr_zero) begin
          phase_d  = ST_DATA;
          tmr_load = 1'b1;
          tmr_val  = DAT_LD;
        end
      end
      ST_DATA: begin
        if (tmr_zero) phase_d = ST_END;
      end
      ST_END: begin
        phase_d  = ST_RECOV;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      ST_RECOV: begin
        if (tmr_zero) phase_d = ST_IDLE;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == ST_RECOV) && tmr_zero;
    end
  end

  assign req_ready = (phase_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign nxt_phase = phase_d;
  assign done      = done_q;

  // R9: done lasts exactly one cycle
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the done cycle is an idle cycle that can take a request
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R2: once a cycle has started, the sequencer is not ready next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R6: the data phase is only left through the end phase
  p_data_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_DATA) |=> (phase_q == ST_DATA || phase_q == ST_END));

endmodule

// File: rtl/sram_wr_pins.sv
`timescale 1ns/1ps
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter bit OE_HELD_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  wr_phase_e         nxt_phase,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              cs_q;
  logic              we_q;
  logic              de_q;
  logic              oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              sel_on;
  logic              wr_on;
  logic              drv_on;

  assign sel_on = (nxt_phase == ST_ADDR) || (nxt_phase == ST_WLOW) ||
                  (nxt_phase == ST_DATA) || (nxt_phase == ST_END);
  assign wr_on  = (nxt_phase == ST_WLOW) || (nxt_phase == ST_DATA);
  assign drv_on = (nxt_phase == ST_DATA) || (nxt_phase == ST_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      we_q   <= 1'b1;
      de_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cs_q <= !sel_on;
      we_q <= !wr_on;
      de_q <= drv_on;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  generate
    if (OE_HELD_LOW) begin : g_oe_low
      assign oe_q = 1'b0;
    end else begin : g_oe_raise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= sel_on;
      end

      // R7: output enable is already high when write enable falls
      p_oe_before_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_q) |-> $past(oe_q));

      // R7: output enable stays high across the whole write window
      p_oe_over_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_q |-> oe_q);
    end
  endgenerate

  assign cs_n    = cs_q;
  assign we_n    = we_q;
  assign oe_n    = oe_q;
  assign addr    = addr_q;
  assign dout    = data_q;
  assign dout_en = de_q;

  // R4: the write window sits inside chip select
  p_we_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> !cs_q);

  // R4: chip select rises one cycle after write enable rises
  p_cs_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |=> $rose(cs_q));

  // R3: chip select was already low before write enable falls
  p_cs_leads_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_q) |-> $past(!cs_q));

  // R3: address holds while chip select stays low
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $past(!cs_q)) |-> $stable(addr_q));

  // R6: data is driven at the moment write enable rises
  p_data_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> de_q);

  // R6: data is off whenever chip select is high
  p_drive_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !de_q);

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int GRADE       = 0,
  parameter bit OE_HELD_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en
);

  localparam int WC_C   = ns_to_cyc(ns_cycle(GRADE), CLK_NS);
  localparam int WP_C   = ns_to_cyc(ns_pulse(GRADE), CLK_NS);
  localparam int CW_C   = ns_to_cyc(ns_cs_end(GRADE), CLK_NS);
  localparam int DW_C   = ns_to_cyc(ns_setup(GRADE), CLK_NS);
  localparam int HZ_C   = ns_to_cyc(ns_turnoff(GRADE), CLK_NS);
  localparam int LOW_B  = imax(imax(WP_C, CW_C - 1), DW_C + 1);
  localparam int LOW_C  = OE_HELD_LOW ? imax(LOW_B, DW_C + HZ_C) : LOW_B;
  localparam int PRE_C  = LOW_C - DW_C;
  localparam int REC_C  = imax(1, WC_C - (LOW_C + 2));
  localparam int LEN_MX = imax(imax(PRE_C, DW_C), REC_C);
  localparam int CNT_W  = imax(1, $clog2(LEN_MX));

  logic      accept;
  wr_phase_e nxt_phase;

  sram_wr_ctrl #(
    .PRE_LEN (PRE_C),
    .DAT_LEN (DW_C),
    .REC_LEN (REC_C),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (wr_valid),
    .req_ready (wr_ready),
    .accept    (accept),
    .nxt_phase (nxt_phase),
    .done      (done)
  );

  sram_wr_pins #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .OE_HELD_LOW (OE_HELD_LOW)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (wr_addr),
    .req_data  (wr_data),
    .nxt_phase (nxt_phase),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .addr      (mem_addr),
    .dout      (mem_dout),
    .dout_en   (mem_dout_en)
  );

  assign busy = !wr_ready;

  // window counters for the timing checks
  logic [15:0] low_run_q;
  logic [15:0] cyc_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
      cyc_run_q <= '0;
    end else begin
      if (!mem_we_n) low_run_q <= low_run_q + 1'b1;
      else           low_run_q <= '0;
      if (accept)    cyc_run_q <= 16'd1;
      else if (busy) cyc_run_q <= cyc_run_q + 1'b1;
    end
  end

  // R5: write enable low for exactly the derived number of cycles
  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_run_q == 16'(LOW_C)));

  // R8: chip-select fall to the earliest next fall covers the cycle minimum
  p_cycle_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_run_q >= 16'(WC_C)));

endmodule

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
module sram_wr_ref #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int GRADE   = 0,
  parameter bit OE_LOW  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [AW-1:0] a_in,
  input  logic [DW-1:0] d_in,
  output logic          e_cs_n,
  output logic          e_we_n,
  output logic          e_oe_n,
  output logic          e_de,
  output logic          e_done,
  output logic          e_ready,
  output logic [AW-1:0] e_addr,
  output logic [DW-1:0] e_data,
  output int            e_low
);
  typedef struct packed {
    logic cs_n; logic we_n; logic oe_n; logic de; logic done;
    logic [AW-1:0] a; logic [DW-1:0] d;
  } ent_t;

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10 grade table, written independently of the design
  int t_wc, t_wp, t_cw, t_dw, t_hz, n_low, n_pre, n_rec;
  initial begin
    t_wc = (GRADE == 0) ? 55 : (GRADE == 1) ? 70 : 85;
    t_wp = (GRADE == 0) ? 35 : (GRADE == 1) ? 50 : 55;
    t_cw = (GRADE == 0) ? 40 : (GRADE == 1) ? 60 : 75;
    t_dw = (GRADE == 0) ? 25 : (GRADE == 1) ? 30 : 35;
    t_hz = (GRADE == 0) ? 20 : (GRADE == 1) ? 25 : 30;
    n_low = mx(mx(up(t_wp), up(t_cw) - 1), up(t_dw) + 1);
    if (OE_LOW) n_low = mx(n_low, up(t_dw) + up(t_hz));
    n_pre = n_low - up(t_dw);
    n_rec = mx(1, up(t_wc) - n_low - 2);
  end
  assign e_low = n_low;

  ent_t q[$];
  ent_t cur;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = '{cs_n:1'b1, we_n:1'b1, oe_n:1'b0, de:1'b0, done:1'b0, a:'0, d:'0};
    end else begin
      if (valid && q.size() == 0) begin
        logic ow;
        ow = !OE_LOW;
        q.push_back('{cs_n:1'b0, we_n:1'b1, oe_n:ow, de:1'b0, done:1'b0, a:a_in, d:d_in});
        for (int i = 0; i < n_pre; i++)
          q.push_back('{cs_n:1'b0, we_n:1'b0, oe_n:ow, de:1'b0, done:1'b0, a:a_in, d:d_in});
        for (int i = 0; i < up(t_dw); i++)
          q.push_back('{cs_n:1'b0, we_n:1'b0, oe_n:ow, de:1'b1, done:1'b0, a:a_in, d:d_in});
        q.push_back('{cs_n:1'b0, we_n:1'b1, oe_n:ow, de:1'b1, done:1'b0, a:a_in, d:d_in});
        for (int i = 0; i < n_rec; i++)
          q.push_back('{cs_n:1'b1, we_n:1'b1, oe_n:1'b0, de:1'b0, done:1'b0, a:a_in, d:d_in});
        q.push_back('{cs_n:1'b1, we_n:1'b1, oe_n:1'b0, de:1'b0, done:1'b1, a:a_in, d:d_in});
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur.done = 1'b0;
    end
    e_cs_n  = cur.cs_n;
    e_we_n  = cur.we_n;
    e_oe_n  = cur.oe_n;
    e_de    = cur.de;
    e_done  = cur.done;
    e_addr  = cur.a;
    e_data  = cur.d;
    e_ready = (q.size() == 0);
  end
endmodule

module sram_wr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit run_chk = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // instance outputs: index 0 = uut, 1 = uut_slow
  logic          rdy [2], bsy [2], dn [2], cs [2], we [2], oe [2], de [2];
  logic [AW-1:0] ma [2];
  logic [DW-1:0] md [2];
  logic          x_cs [2], x_we [2], x_oe [2], x_de [2], x_dn [2], x_rdy [2];
  logic [AW-1:0] x_a [2];
  logic [DW-1:0] x_d [2];
  int            x_low [2];

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD), .GRADE(0), .OE_HELD_LOW(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(valid), .wr_ready(rdy[0]), .wr_addr(addr), .wr_data(data),
    .busy(bsy[0]), .done(dn[0]), .mem_cs_n(cs[0]), .mem_we_n(we[0]), .mem_oe_n(oe[0]),
    .mem_addr(ma[0]), .mem_dout(md[0]), .mem_dout_en(de[0]));

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD), .GRADE(2), .OE_HELD_LOW(1'b0)) uut_slow (
    .clk(clk), .rst_n(rst_n), .wr_valid(valid), .wr_ready(rdy[1]), .wr_addr(addr), .wr_data(data),
    .busy(bsy[1]), .done(dn[1]), .mem_cs_n(cs[1]), .mem_we_n(we[1]), .mem_oe_n(oe[1]),
    .mem_addr(ma[1]), .mem_dout(md[1]), .mem_dout_en(de[1]));

  sram_wr_ref #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .GRADE(0), .OE_LOW(1'b1)) ref_fast (
    .clk(clk), .rst_n(rst_n), .valid(valid), .a_in(addr), .d_in(data),
    .e_cs_n(x_cs[0]), .e_we_n(x_we[0]), .e_oe_n(x_oe[0]), .e_de(x_de[0]), .e_done(x_dn[0]),
    .e_ready(x_rdy[0]), .e_addr(x_a[0]), .e_data(x_d[0]), .e_low(x_low[0]));

  sram_wr_ref #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .GRADE(2), .OE_LOW(1'b0)) ref_slow (
    .clk(clk), .rst_n(rst_n), .valid(valid), .a_in(addr), .d_in(data),
    .e_cs_n(x_cs[1]), .e_we_n(x_we[1]), .e_oe_n(x_oe[1]), .e_de(x_de[1]), .e_done(x_dn[1]),
    .e_ready(x_rdy[1]), .e_addr(x_a[1]), .e_data(x_d[1]), .e_low(x_low[1]));

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference models
  int low_run [2] = '{0, 0};
  localparam int HAND_LOW [2] = '{5, 7};  // R10 worked examples

  always @(negedge clk) begin
    if (run_chk) begin
      for (int k = 0; k < 2; k++) begin
        chk(rdy[k] == x_rdy[k], "R2", "ready", rdy[k], x_rdy[k]);
        chk(bsy[k] == !x_rdy[k], "R2", "busy", bsy[k], !x_rdy[k]);
        chk(cs[k] == x_cs[k], "R3", "cs_n", cs[k], x_cs[k]);
        chk(we[k] == x_we[k], "R5", "we_n", we[k], x_we[k]);
        chk(!(!we[k] && cs[k]), "R4", "we low outside cs", we[k], cs[k]);
        chk(oe[k] == x_oe[k], "R7", "oe_n", oe[k], x_oe[k]);
        chk(de[k] == x_de[k], "R6", "dout_en", de[k], x_de[k]);
        chk(dn[k] == x_dn[k], "R9", "done", dn[k], x_dn[k]);
        if (!x_cs[k]) chk(ma[k] == x_a[k], "R3", "addr", ma[k], x_a[k]);
        if (x_de[k])  chk(md[k] == x_d[k], "R6", "dout", md[k], x_d[k]);
        if (!we[k]) low_run[k]++;
        else if (low_run[k] != 0) begin
          chk(low_run[k] == HAND_LOW[k], "R10", "we low length", low_run[k], HAND_LOW[k]);
          chk(low_run[k] == x_low[k], "R5", "we low length", low_run[k], x_low[k]);
          low_run[k] = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 200000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin  // R1 reset state
      chk(cs[k] && we[k], "R1", "strobes in reset", {cs[k], we[k]}, 2'b11);
      chk(oe[k] == 1'b0, "R1", "oe_n in reset", oe[k], 0);
      chk(de[k] == 1'b0, "R1", "dout_en in reset", de[k], 0);
      chk(rdy[k] && !bsy[k] && !dn[k], "R1", "ready/busy/done in reset", {rdy[k], bsy[k], dn[k]}, 3'b100);
    end
    rst_n = 1'b1;
    run_chk = 1'b1;
    // sparse and dense requests landing in every phase (R2 hold-off)
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      valid = ($urandom % 4) == 0;
      addr = AW'($urandom);
      data = DW'($urandom);
    end
    // valid held high: every done cycle is also an acceptance (R9)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      valid = 1'b1;
      addr = AW'($urandom);
      data = DW'($urandom);
    end
    // short pulses, often while busy (R2)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      valid = ($urandom % 7) == 0;
      addr = AW'($urandom);
      data = DW'($urandom);
    end
    @(negedge clk);
    valid = 1'b0;
    repeat (40) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule